// File: doc/BRIEF.md
# Frame Dump Serial Packet Formatter

This block turns a stored grayscale frame into the byte stream that a byte-wide serial transmitter carries to a host. When the caller requests a packet, it sends a marker byte that opens the packet. It then sends one byte for every pixel it reads from a synchronous frame memory, and closes the packet with a second marker byte. Markers are told apart from pixel data in-band: only the two markers have their top bit clear. Each pixel is therefore reduced to its seven upper bits.

Two packet kinds share the same framing. A frame-dump packet carries the whole square frame. Its side length comes from a 4-bit size code. A decode packet carries a caller-chosen number of payload bytes. The caller places these in the same memory, starting at address 0. The output is a registered byte with a valid/ready handshake. Memory reads are issued ahead of the output, so the payload streams at one byte per cycle while the receiver keeps ready high.

Top module: `frame_pkt_fmt`

## Requirements
- R1: During and directly after reset, `tx_valid_o`, `done_o` and `mem_rd_o` are 0.
- R2: The first byte of a packet is the opening marker. Bit 7 = 0. Bit 6 = 1 for a frame dump and 0 for decode. Bit 5 = 0. Bit 4 = 0. Bits 3..0 hold the size code that was sampled with the start request.
- R3: Payload byte k is `{1'b1, pixel[7:1]}`, where `pixel` is the memory word at address k. Payload bytes run from address 0 upward, with no gaps and no repeats.
- R4: The last byte of a packet is the closing marker. Bit 7 = 0. Bit 6 is the packet kind. Bit 5 = 1. Bits 4..0 = 0.
- R5: In frame-dump mode the payload holds side×side bytes. side = min(SIDE_BASE + SIDE_STEP×code, SIDE_MAX).
- R6: In decode mode the payload holds min(`dec_len_i`, SIDE_MAX²) bytes. A length of 0 gives the opening marker followed at once by the closing marker.
- R7: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` stay unchanged. Each byte is delivered exactly once.
- R8: A start request seen while a packet is in progress has no effect. It does not alter the packet in flight, and no second packet follows it.
- R9: `done_o` is high for exactly one cycle, in the cycle after the closing marker is accepted.
- R10: While `tx_ready_i` stays high, successive payload bytes are accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Packet request, sampled only while idle |
| dump_mode_i | input | 1 | 1 = frame dump, 0 = decode packet |
| size_code_i | input | 4 | Frame size code |
| dec_len_i | input | LEN_W | Payload length for decode packets |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_data_i | input | 8 | Memory data, valid the cycle after the strobe |
| tx_data_o | output | 8 | Byte toward the transmitter |
| tx_valid_o | output | 1 | Byte is valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| done_o | output | 1 | One-cycle pulse after the closing marker |

## Verification
Every cycle, the assertions check the following:
- a stalled byte holds steady;
- reserved marker bits stay zero;
- `done_o` never lasts two cycles;
- a start request during a packet leaves the latched configuration alone;
- the prefetch buffer never overflows;
- every memory read stays below the packet length.

Only the bench scenarios can show the rest. That covers the exact byte sequence against a model of memory, and the payload counts for each size code, including the clamped code. It also covers the zero-length and overlong decode lengths, back-to-back payload timing with ready held high, and the absence of a second packet after a start request made while busy.

// File: rtl/frame_pkt_pkg.sv
package frame_pkt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_TAIL = 2'd2
  } fmt_state_e;

  // Opening marker: top bit clear, kind bit, bit5 clear, reserved bit4 clear, size code.
  function automatic logic [7:0] open_marker(input logic dump, input logic [3:0] code);
    return {1'b0, dump, 1'b0, 1'b0, code};
  endfunction

  // Closing marker: top bit clear, kind bit, bit5 set, remaining bits reserved zero.
  function automatic logic [7:0] close_marker(input logic dump);
    return {1'b0, dump, 1'b1, 5'b00000};
  endfunction

  // Payload: top bit set, the seven upper pixel bits below it.
  function automatic logic [7:0] pixel_byte(input logic [7:0] pix);
    return {1'b1, pix[7:1]};
  endfunction

endpackage

// File: rtl/frame_side_lut.sv
module frame_side_lut #(
  parameter int SIDE_BASE = 190,
  parameter int SIDE_STEP = 2,
  parameter int SIDE_MAX  = 210,
  parameter int LEN_W     = 16
) (
  input  logic [3:0]       code_i,
  output logic [LEN_W-1:0] pixels_o
);

  logic [LEN_W-1:0] tbl [16];

  for (genvar g = 0; g < 16; g++) begin : g_entry
    localparam int RAW  = SIDE_BASE + SIDE_STEP * g;
    localparam int SIDE = (RAW > SIDE_MAX) ? SIDE_MAX : RAW;
    assign tbl[g] = LEN_W'(SIDE * SIDE);
  end

  assign pixels_o = tbl[code_i];

endmodule

// File: rtl/pixel_prefetch.sv
module pixel_prefetch #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              out_valid_i,
  input  logic              out_accept_i,
  input  logic              take_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              avail_o,
  output logic [7:0]        pix_o
);

  logic [LEN_W-1:0] fetch_idx;
  logic             rd_pend;
  logic             pf_valid;
  logic [7:0]       pf_data;
  logic [2:0]       items;
  logic             issue;

  // Bytes held downstream after this cycle's acceptance: output slot, buffer, read in flight.
  always_comb begin
    items = {2'b00, out_valid_i} + {2'b00, pf_valid} + {2'b00, rd_pend}
          - {2'b00, out_accept_i};
    issue = enable_i && (fetch_idx < len_i) && (items < 3'd2);
  end

  assign mem_rd_o   = issue;
  assign mem_addr_o = fetch_idx[ADDR_W-1:0];
  assign avail_o    = pf_valid || rd_pend;
  assign pix_o      = pf_valid ? pf_data : mem_data_i;

  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      fetch_idx <= '0;
      rd_pend   <= 1'b0;
      pf_valid  <= 1'b0;
      pf_data   <= '0;
    end else begin
      rd_pend <= issue;
      if (issue) fetch_idx <= fetch_idx + 1'b1;
      if (take_i) begin
        if (pf_valid) begin
          pf_valid <= rd_pend;
          if (rd_pend) pf_data <= mem_data_i;
        end
      end else if (rd_pend) begin
        pf_valid <= 1'b1;
        pf_data  <= mem_data_i;
      end
    end
  end

  AST_PF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && pf_valid) |-> take_i); // R10

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> (LEN_W'(mem_addr_o) < len_i)); // R3

endmodule

// File: rtl/frame_pkt_fmt.sv
module frame_pkt_fmt
  import frame_pkt_pkg::*;
#(
  parameter int SIDE_BASE = 190,
  parameter int SIDE_STEP = 2,
  parameter int SIDE_MAX  = 210,
  localparam int MAX_PIX  = SIDE_MAX * SIDE_MAX,
  localparam int LEN_W    = $clog2(MAX_PIX + 1),
  localparam int ADDR_W   = $clog2(MAX_PIX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dump_mode_i,
  input  logic [3:0]        size_code_i,
  input  logic [LEN_W-1:0]  dec_len_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              done_o
);

  fmt_state_e       state;
  logic             mode_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] loaded;
  logic [7:0]       tx_data_q;
  logic             tx_valid_q;
  logic             done_q;

  logic [LEN_W-1:0] frame_pixels;
  logic [LEN_W-1:0] dec_len_clamped;
  logic             out_free;
  logic             out_accept;
  logic             avail;
  logic [7:0]       pix;
  logic             take;

  frame_side_lut #(
    .SIDE_BASE(SIDE_BASE),
    .SIDE_STEP(SIDE_STEP),
    .SIDE_MAX (SIDE_MAX),
    .LEN_W    (LEN_W)
  ) u_lut (
    .code_i  (size_code_i),
    .pixels_o(frame_pixels)
  );

  assign dec_len_clamped = (dec_len_i > LEN_W'(MAX_PIX)) ? LEN_W'(MAX_PIX) : dec_len_i;
  assign out_accept      = tx_valid_q && tx_ready_i;
  assign out_free        = !tx_valid_q || tx_ready_i;
  assign take            = (state == ST_BODY) && out_free && avail;

  pixel_prefetch #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .enable_i    (state == ST_BODY),
    .len_i       (len_q),
    .out_valid_i (tx_valid_q),
    .out_accept_i(out_accept),
    .take_i      (take),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_i  (mem_data_i),
    .avail_o     (avail),
    .pix_o       (pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mode_q     <= 1'b0;
      len_q      <= '0;
      loaded     <= '0;
      tx_data_q  <= '0;
      tx_valid_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            mode_q     <= dump_mode_i;
            len_q      <= dump_mode_i ? frame_pixels : dec_len_clamped;
            loaded     <= '0;
            tx_data_q  <= open_marker(dump_mode_i, size_code_i);
            tx_valid_q <= 1'b1;
            state      <= ST_BODY;
          end
        end
        ST_BODY: begin
          if (out_free) begin
            if (avail) begin
              tx_data_q  <= pixel_byte(pix);
              tx_valid_q <= 1'b1;
              loaded     <= loaded + 1'b1;
            end else if (loaded == len_q) begin
              tx_data_q  <= close_marker(mode_q);
              tx_valid_q <= 1'b1;
              state      <= ST_TAIL;
            end else begin
              tx_valid_q <= 1'b0;
            end
          end
        end
        ST_TAIL: begin
          if (tx_ready_i) begin
            tx_valid_q <= 1'b0;
            done_q     <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_data_o  = tx_data_q;
  assign tx_valid_o = tx_valid_q;
  assign done_o     = done_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_q && !tx_ready_i) |=> (tx_valid_q && $stable(tx_data_q))); // R7

  AST_OPEN_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_q && !tx_data_q[7]) |-> !tx_data_q[4]); // R2

  AST_CLOSE_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_q && !tx_data_q[7] && tx_data_q[5]) |-> (tx_data_q[4:0] == 5'd0)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_IDLE) && start_i) |=> ($stable(len_q) && $stable(mode_q))); // R8

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    len_q <= LEN_W'(MAX_PIX)); // R6

endmodule

// File: tb/sim_frame_pkt_fmt.sv
`timescale 1ns/1ps
module sim_frame_pkt_fmt;

  localparam int SB      = 3;
  localparam int SS      = 1;
  localparam int SM      = 7;
  localparam int MAX_PIX = SM * SM;
  localparam int LEN_W   = $clog2(MAX_PIX + 1);
  localparam int ADDR_W  = $clog2(MAX_PIX);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              dmode = 1'b0;
  logic [3:0]        code = '0;
  logic [LEN_W-1:0]  dlen = '0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_q = '0;
  logic [7:0]        tx_data;
  logic              tx_valid;
  logic              tx_ready = 1'b0;
  logic              done;

  logic [7:0] mem [64];

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];

  frame_pkt_fmt #(.SIDE_BASE(SB), .SIDE_STEP(SS), .SIDE_MAX(SM)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .dump_mode_i(dmode),
    .size_code_i(code), .dec_len_i(dlen), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_data_i(mem_q), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input bit m, input int c, input int dl);
    int s;
    s = SB + SS * c;
    if (s > SM) s = SM;
    if (m) return s * s;
    return (dl > MAX_PIX) ? MAX_PIX : dl;
  endfunction

  function automatic logic [7:0] exp_open(input bit m, input int c);
    return {1'b0, m, 2'b00, 4'(c)};
  endfunction

  function automatic logic [7:0] exp_close(input bit m);
    return {1'b0, m, 1'b1, 5'd0};
  endfunction

  task automatic run_packet(input bit m, input int c, input int dl, input int pct, input bit poke);
    logic [7:0] rx [160];
    int  acc [160];
    int  n = 0;
    int  n_exp;
    bit  hold_bad = 0;
    bit  done_bad = 0;
    int  done_cnt = 0;
    bit  foot_prev = 0;
    bit  pv = 0;
    bit  pr = 0;
    logic [7:0] pd = '0;
    bit  fin = 0;
    bit  data_bad = 0;
    n_exp = exp_len(m, c, dl);
    @(negedge clk);
    start = 1'b1; dmode = m; code = 4'(c); dlen = LEN_W'(dl);
    @(negedge clk);
    start = 1'b0; dmode = ~m; code = ~code; dlen = '0;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (done !== foot_prev) done_bad = 1;
      if (done) done_cnt++;
      if (foot_prev) fin = 1;
      foot_prev = 0;
      if (pv && !pr && (!tx_valid || tx_data !== pd)) hold_bad = 1;
      tx_ready = (($urandom % 100) < pct);
      start = (poke && (cyc == 3 || cyc == 4));
      if (!fin && tx_valid && tx_ready && n < 160) begin
        rx[n] = tx_data; acc[n] = cyc; n++;
        if (n == n_exp + 2) foot_prev = 1;
      end
      pv = tx_valid; pr = tx_ready; pd = tx_data;
    end
    start = 1'b0;
    tx_ready = 1'b0;
    chk(n == n_exp + 2, (m ? "R5 dump byte count" : "R6 decode byte count"), n, n_exp + 2);
    chk(rx[0] === exp_open(m, c), "R2 opening marker", rx[0], exp_open(m, c));
    for (int i = 0; i < n_exp && i + 1 < n; i++)
      if (rx[i+1] !== {1'b1, mem[i][7:1]}) data_bad = 1;
    chk(!data_bad, "R3 payload bytes", data_bad, 0);
    chk(n >= 2 && rx[n-1] === exp_close(m), "R4 closing marker", rx[n-1], exp_close(m));
    chk(!hold_bad, "R7 stalled byte held", hold_bad, 0);
    chk(!done_bad && done_cnt == 1, "R9 done pulse", done_cnt, 1);
    if (pct == 100 && n_exp > 1)
      chk(acc[n_exp] - acc[1] == n_exp - 1, "R10 back-to-back payload", acc[n_exp] - acc[1], n_exp - 1);
    if (poke) begin
      bit extra = 0;
      tx_ready = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (tx_valid) extra = 1;
      end
      tx_ready = 1'b0;
      chk(!extra, "R8 start while busy ignored", extra, 0);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!tx_valid && !done && !mem_rd, "R1 reset outputs", {tx_valid, done, mem_rd}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !done && !mem_rd, "R1 idle after reset", {tx_valid, done, mem_rd}, 0);
    run_packet(1'b1, 0, 0, 100, 1'b0);   // R5 smallest frame, full rate
    run_packet(1'b1, 4, 0, 50, 1'b1);    // R5 largest, R8 poke
    run_packet(1'b1, 9, 0, 30, 1'b0);    // R5 clamped code
    run_packet(1'b0, 5, 5, 70, 1'b0);    // R6 short decode
    run_packet(1'b0, 2, 0, 100, 1'b0);   // R6 zero length
    run_packet(1'b0, 1, 63, 100, 1'b1);  // R6 clamp, R8 poke
    for (int r = 0; r < 6; r++)
      run_packet(1'b1 & 1'($urandom), int'($urandom % 16), int'($urandom % 64),
                 int'(20 + $urandom % 81), 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule